// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block decides the fate of a jump-class instruction in a small controller that has no status flags and no target addresses. The control path offers it one instruction together with the value of the register to be tested, the instruction's optional 16-bit immediate and the current instruction pointer. The block XORs the tested value with the immediate and tests the result. The immediate is sign-extended in the long form and forced to zero in the short form. The test is either "all zero" or "least significant bit set", and a negate flag can invert it. A taken branch does not load an address. It names which of four prefetch queues becomes the current queue.

The block is a three-state machine. **IDLE** accepts an offer. The **accept** transition (IDLE to DECIDE) is taken when the offer is a jump-class instruction. **DECIDE** presents the verdict for exactly one cycle. From DECIDE, the **finish** transition returns to IDLE, and the **link** transition (DECIDE to LINK) is taken when the branch is taken and the link flag is set. **LINK** issues one register-write request that carries the address of the instruction after the jump. The **return** transition then leads from LINK back to IDLE. The unconditional form of a jump is just a test that is known to pass, for example an even test on an instruction pointer.

Top module: `cbe_top`

## Requirements
- R1: After reset the block is in IDLE. `ready_o` is 1, and `resolve_o`, `taken_o`, `queue_o`, `link_we_o`, `link_reg_o` and `link_data_o` are all 0.
- R2: An offer is accepted only on a clock edge where `issue_i` and `ready_o` are both 1 and the class field `instr_i[2:1]` equals 2'b10. Any other offer is ignored: no verdict follows and `ready_o` stays 1.
- R3: In the cycle after an accepted offer, `resolve_o` is 1 for exactly one cycle and `ready_o` is 0.
- R4: When `instr_i[8]` is 0 (zero test), the branch is taken when the XOR of the tested value and the immediate is all zero. When `instr_i[9]` is 1, the result is inverted.
- R5: When `instr_i[8]` is 1 (odd test), the branch is taken when bit 0 of that XOR is 1. When `instr_i[9]` is 1, the result is inverted.
- R6: When `instr_i[0]` is 1 (long form), the immediate is `imm_i` sign-extended from bit 15 to 32 bits. When `instr_i[0]` is 0 (short form), the immediate is zero and `imm_i` has no effect.
- R7: While `resolve_o` is 1, `taken_o` gives the verdict. `queue_o` equals `instr_i[12:11]` when the branch is taken and is 0 otherwise.
- R8: When the branch is taken and `instr_i[10]` is 1, the cycle after the verdict has `link_we_o` set to 1 for one cycle and `ready_o` set to 0. In that cycle `link_reg_o` equals `instr_i[7:4]`, and `link_data_o` equals `ip_i` plus 4 in the long form or plus 2 in the short form.
- R9: When the branch is not taken, or `instr_i[10]` is 0, no link write occurs and `ready_o` returns to 1 in the cycle after the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | An instruction is offered this cycle |
| instr_i | input | 16 | Instruction half-word holding the form, class, link register and jump flags |
| imm_i | input | 16 | Immediate half-word, used in the long form only |
| tested_i | input | 32 | Value of the register to be tested |
| ip_i | input | 32 | Address of the offered instruction |
| ready_o | output | 1 | The machine is in IDLE and can accept an offer |
| resolve_o | output | 1 | A verdict is present this cycle |
| taken_o | output | 1 | The branch is taken |
| queue_o | output | 2 | Queue that becomes current when the branch is taken |
| link_we_o | output | 1 | Write request for the return address |
| link_reg_o | output | 4 | Register index for the return address |
| link_data_o | output | 32 | Return address |

## Verification
A wrong verdict or a wrong captured field shows up on `taken_o` or `queue_o` in the single DECIDE cycle, one clock after acceptance. A corrupted return address or register index shows up on the link outputs one clock later. A state machine that sticks in a state or skips one breaks the fixed rhythm of `ready_o`, `resolve_o` and `link_we_o` within two cycles of an offer. For that reason, the model is compared against every output on every clock.

// File: rtl/cbe_pkg.sv
package cbe_pkg;

    localparam int QSEL_W = 2;
    localparam int RIDX_W = 4;
    localparam logic [1:0] JUMP_CLASS = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_LINK   = 2'd2
    } cbe_state_e;

    typedef struct packed {
        logic              is_jump;
        logic              long_form;
        logic              odd_test;
        logic              negate;
        logic              link;
        logic [QSEL_W-1:0] queue;
        logic [RIDX_W-1:0] link_reg;
    } jump_fields_t;

endpackage

// File: rtl/cbe_decode.sv
module cbe_decode
    import cbe_pkg::*;
#(
    parameter int ILEN = 16
) (
    input  logic [ILEN-1:0] instr,
    output jump_fields_t    fields
);
    // Field positions: [0] long form, [2:1] class, [7:4] link register,
    // [8] odd test, [9] negate, [10] link, [12:11] queue.
    always_comb begin
        fields.long_form = instr[0];
        fields.is_jump   = (instr[2:1] == JUMP_CLASS);
        fields.link_reg  = instr[7:4];
        fields.odd_test  = instr[8];
        fields.negate    = instr[9];
        fields.link      = instr[10];
        fields.queue     = instr[12:11];
    end
endmodule

// File: rtl/cbe_cond.sv
module cbe_cond #(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic [XLEN-1:0] tested,
    input  logic [IMMW-1:0] imm,
    input  logic            long_form,
    input  logic            odd_test,
    input  logic            negate,
    output logic            take
);
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] mixed;
    logic            raw;

    generate
        if (XLEN > IMMW) begin : g_sext
            assign imm_ext = long_form ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm} : '0;
        end else begin : g_trunc
            assign imm_ext = long_form ? imm[XLEN-1:0] : '0;
        end
    endgenerate

    always_comb begin
        mixed = tested ^ imm_ext;
        raw   = odd_test ? mixed[0] : (mixed == '0);
        take  = raw ^ negate;
    end
endmodule

// File: rtl/cbe_link.sv
module cbe_link #(
    parameter int XLEN       = 32,
    parameter int SHORT_STEP = 2,
    parameter int LONG_STEP  = 4
) (
    input  logic [XLEN-1:0] ip,
    input  logic            long_form,
    output logic [XLEN-1:0] next_ip
);
    localparam logic [XLEN-1:0] SSTEP = XLEN'(SHORT_STEP);
    localparam logic [XLEN-1:0] LSTEP = XLEN'(LONG_STEP);

    assign next_ip = ip + (long_form ? LSTEP : SSTEP);
endmodule

// File: rtl/cbe_top.sv
module cbe_top
    import cbe_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ILEN = 16,
    parameter int IMMW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_i,
    input  logic [ILEN-1:0]     instr_i,
    input  logic [IMMW-1:0]     imm_i,
    input  logic [XLEN-1:0]     tested_i,
    input  logic [XLEN-1:0]     ip_i,
    output logic                ready_o,
    output logic                resolve_o,
    output logic                taken_o,
    output logic [QSEL_W-1:0]   queue_o,
    output logic                link_we_o,
    output logic [RIDX_W-1:0]   link_reg_o,
    output logic [XLEN-1:0]     link_data_o
);
    cbe_state_e   state_q, state_d;
    jump_fields_t dec;
    jump_fields_t fld_q;
    logic         take_now, take_q;
    logic [XLEN-1:0] nip_now, nip_q;
    logic         accept;

    cbe_decode #(.ILEN(ILEN)) u_decode (
        .instr  (instr_i),
        .fields (dec)
    );

    cbe_cond #(.XLEN(XLEN), .IMMW(IMMW)) u_cond (
        .tested    (tested_i),
        .imm       (imm_i),
        .long_form (dec.long_form),
        .odd_test  (dec.odd_test),
        .negate    (dec.negate),
        .take      (take_now)
    );

    cbe_link #(.XLEN(XLEN)) u_link (
        .ip        (ip_i),
        .long_form (dec.long_form),
        .next_ip   (nip_now)
    );

    assign accept = (state_q == ST_IDLE) && issue_i && dec.is_jump;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_DECIDE;
            ST_DECIDE: state_d = (take_q && fld_q.link) ? ST_LINK : ST_IDLE;
            ST_LINK:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fld_q   <= '0;
            take_q  <= 1'b0;
            nip_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                fld_q  <= dec;
                take_q <= take_now;
                nip_q  <= nip_now;
            end
        end
    end

    // outputs
    always_comb begin
        ready_o     = 1'b0;
        resolve_o   = 1'b0;
        taken_o     = 1'b0;
        queue_o     = '0;
        link_we_o   = 1'b0;
        link_reg_o  = '0;
        link_data_o = '0;
        unique case (state_q)
            ST_IDLE: ready_o = 1'b1;
            ST_DECIDE: begin
                resolve_o = 1'b1;
                taken_o   = take_q;
                queue_o   = take_q ? fld_q.queue : '0;
            end
            ST_LINK: begin
                link_we_o   = 1'b1;
                link_reg_o  = fld_q.link_reg;
                link_data_o = nip_q;
            end
            default: ready_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cbe_checker.sv
module cbe_checker #(
    parameter int ILEN = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_i,
    input logic [ILEN-1:0] instr_i,
    input logic            ready_o,
    input logic            resolve_o,
    input logic            taken_o,
    input logic [1:0]      queue_o,
    input logic            link_we_o
);
    // R2, R3: a verdict follows only an accepted jump-class offer
    a_r3_resolve_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_o |-> $past(rst_n && issue_i && ready_o && instr_i[2:1] == 2'b10));

    // R3: no new offer is accepted while a verdict is shown
    a_r3_busy_during_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_o |-> !ready_o);

    // R7: the queue index is zero unless the branch is taken
    a_r7_queue_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> (queue_o == 2'b00));

    // R4/R5: the taken flag only appears with a verdict
    a_r4_taken_with_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> resolve_o);

    // R8: a link write directly follows a taken verdict
    a_r8_link_after_taken: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> ($past(taken_o) && $past(resolve_o) && !ready_o));

    // R9: a not-taken verdict returns the machine to IDLE next cycle
    a_r9_ready_after_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_o && !taken_o) |=> (ready_o && !link_we_o));
endmodule

bind cbe_top cbe_checker #(.ILEN(ILEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_i   (issue_i),
    .instr_i   (instr_i),
    .ready_o   (ready_o),
    .resolve_o (resolve_o),
    .taken_o   (taken_o),
    .queue_o   (queue_o),
    .link_we_o (link_we_o)
);

// File: tb/cbe_top_tb.sv
module cbe_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] tested_i = '0;
    logic [31:0] ip_i = '0;
    logic        ready_o, resolve_o, taken_o, link_we_o;
    logic [1:0]  queue_o;
    logic [3:0]  link_reg_o;
    logic [31:0] link_data_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    cbe_top u_dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
        .imm_i(imm_i), .tested_i(tested_i), .ip_i(ip_i),
        .ready_o(ready_o), .resolve_o(resolve_o), .taken_o(taken_o),
        .queue_o(queue_o), .link_we_o(link_we_o), .link_reg_o(link_reg_o),
        .link_data_o(link_data_o)
    );

    // behavioural reference
    bit          m_ready = 1'b1, m_resolve, m_taken, m_link_we, m_pend;
    bit [1:0]    m_queue;
    bit [3:0]    m_lreg, p_lreg;
    bit [31:0]   m_ldata, p_ldata;

    function automatic bit verdict(input bit [15:0] ins, input bit [15:0] imm,
                                   input bit [31:0] val);
        bit [31:0] k;
        bit [31:0] x;
        bit r;
        k = ins[0] ? {{16{imm[15]}}, imm} : 32'd0; // R6
        x = val ^ k;
        if (ins[8]) r = x[0];          // R5
        else        r = (x == 32'd0);  // R4
        return r ^ ins[9];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ready = 1; m_resolve = 0; m_taken = 0; m_queue = 0;
            m_link_we = 0; m_lreg = 0; m_ldata = 0; m_pend = 0;
        end else begin
            bit nr;
            bit t;
            nr = 1;
            m_resolve = 0; m_taken = 0; m_queue = 0;
            m_link_we = 0; m_lreg = 0; m_ldata = 0;
            if (m_pend) begin
                m_link_we = 1; m_lreg = p_lreg; m_ldata = p_ldata;
                m_pend = 0; nr = 0;
            end else if (m_ready && issue_i && instr_i[2:1] == 2'b10) begin
                t = verdict(instr_i, imm_i, tested_i);
                m_resolve = 1; m_taken = t;
                m_queue = t ? instr_i[12:11] : 2'b00;
                if (t && instr_i[10]) begin
                    m_pend = 1;
                    p_lreg = instr_i[7:4];
                    p_ldata = ip_i + (instr_i[0] ? 32'd4 : 32'd2);
                end
                nr = 0;
            end
            m_ready = nr;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        check(ready_o === m_ready, "R3", "ready", 32'(ready_o), 32'(m_ready));
        check(resolve_o === m_resolve, "R2", "resolve", 32'(resolve_o), 32'(m_resolve));
        check(taken_o === m_taken, "R4/R5", "taken", 32'(taken_o), 32'(m_taken));
        check(queue_o === m_queue, "R7", "queue", 32'(queue_o), 32'(m_queue));
        check(link_we_o === m_link_we, "R8", "link_we", 32'(link_we_o), 32'(m_link_we));
        check(link_reg_o === m_lreg, "R8", "link_reg", 32'(link_reg_o), 32'(m_lreg));
        check(link_data_o === m_ldata, "R8", "link_data", link_data_o, m_ldata);
    end

    function automatic bit [15:0] mk(input bit lng, input bit [1:0] cls, input bit [3:0] lr,
                                     input bit odd, input bit neg, input bit lnk,
                                     input bit [1:0] q);
        return {3'b101, q, lnk, neg, odd, lr, 1'b1, cls, lng};
    endfunction

    task automatic offer(input bit [15:0] ins, input bit [15:0] imm,
                         input bit [31:0] val, input bit [31:0] ip, input int hold);
        @(negedge clk);
        issue_i = 1; instr_i = ins; imm_i = imm; tested_i = val; ip_i = ip;
        repeat (hold) @(negedge clk);
        issue_i = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready_o === 1 && resolve_o === 0 && taken_o === 0 && queue_o === 0 &&
              link_we_o === 0 && link_reg_o === 0 && link_data_o === 0,
              "R1", "reset outputs", {link_data_o[27:0], ready_o, resolve_o, taken_o, link_we_o},
              32'h8);
        rst_n = 1;
        // R4 zero test taken / not taken, negated
        offer(mk(0, 2'b10, 4'hB, 0, 0, 0, 2'd1), 16'h0, 32'h0, 32'h100, 1);
        offer(mk(0, 2'b10, 4'hB, 0, 0, 0, 2'd1), 16'h0, 32'h5, 32'h100, 1);
        offer(mk(0, 2'b10, 4'hB, 0, 1, 0, 2'd3), 16'h0, 32'h5, 32'h100, 1);
        // R5 odd / even tests
        offer(mk(0, 2'b10, 4'h2, 1, 0, 0, 2'd2), 16'h0, 32'h7, 32'h100, 1);
        offer(mk(0, 2'b10, 4'h2, 1, 1, 0, 2'd2), 16'h0, 32'h7, 32'h100, 1);
        // unconditional: even test on an instruction pointer
        offer(mk(0, 2'b10, 4'h2, 1, 1, 0, 2'd3), 16'h0, 32'h2000, 32'h100, 1);
        // R6 long form: sign-extended immediate cancels the value
        offer(mk(1, 2'b10, 4'h1, 0, 0, 0, 2'd2), 16'hFF80, 32'hFFFF_FF80, 32'h100, 1);
        // R6 short form: immediate has no effect
        offer(mk(0, 2'b10, 4'h1, 0, 0, 0, 2'd2), 16'h1234, 32'h0, 32'h100, 1);
        offer(mk(0, 2'b10, 4'h1, 1, 0, 0, 2'd2), 16'h0001, 32'h0, 32'h100, 1);
        // R8 link, long and short forms
        offer(mk(1, 2'b10, 4'hB, 0, 0, 1, 2'd1), 16'h0, 32'h0, 32'h0000_0400, 1);
        offer(mk(0, 2'b10, 4'h9, 1, 0, 1, 2'd3), 16'h0, 32'h1, 32'hFFFF_FFFE, 1);
        // R9 link flag but not taken
        offer(mk(0, 2'b10, 4'h9, 0, 0, 1, 2'd3), 16'h0, 32'h1, 32'h300, 1);
        // R2 other classes ignored; offers held while busy ignored
        offer(mk(0, 2'b01, 4'h9, 0, 0, 1, 2'd3), 16'h0, 32'h0, 32'h300, 1);
        offer(mk(1, 2'b11, 4'h9, 0, 0, 0, 2'd1), 16'h0, 32'h0, 32'h300, 1);
        offer(mk(0, 2'b10, 4'h4, 0, 0, 1, 2'd2), 16'h0, 32'h0, 32'h500, 5);
        // mixed patterns
        for (int i = 0; i < 200; i++) begin
            bit [31:0] s;
            s = 32'h9E37_79B9 * (i + 1);
            offer({s[15:3], 1'b1, s[2:0] == 0 ? 2'b01 : 2'b10, s[4]},
                  s[31:16], (s[5] ? 32'h0 : s ^ 32'h55), s & 32'hFFFF_FFFE, 1 + (i % 3));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule